// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one successive-approximation conversion. A conversion can start in two ways: from a dedicated start strobe, or from chip select and read asserted in the same cycle. When a conversion starts, the block moves the track-and-hold into hold, drops the active-low busy flag and enables the conversion clock. It then spends one clock cycle on each bit trial, from the most significant bit to the least significant bit. The approximation register drives the internal DAC through `trialCode`. A comparator bit, `cmpHigh`, reports whether the analog input is at or above the trial level.

On the last trial the resolved code goes to the output latch, and the approximation register is cleared for the next conversion. In that same cycle, busy returns high, the track-and-hold goes back to tracking and the clock enable drops. Start requests that arrive during a conversion are discarded. While the block is idle, a clock that keeps running has no effect on it.

Top module: `sar_conv_seq`

## Requirements
- R1: A one-cycle high on `startStrobe` while `busyN` is high starts a conversion. `busyN` reads low after the next rising edge.
- R2: `chipSel` and `readEn` high in the same cycle while idle start a conversion. Either one high alone does not start one.
- R3: After a start, `busyN` stays low for exactly DATA_W clock cycles and then returns high.
- R4: `holdMode` is 1 (hold) exactly while `busyN` is low, and 0 (track) at all other times.
- R5: Each trial sets the bit under test to 1 on `trialCode`. The bit is kept if `cmpHigh` is 1 (input at or above the trial level) and cleared otherwise. Bits are resolved from bit DATA_W-1 down to bit 0, so `result` equals the input code in straight binary.
- R6: `result` keeps its previous value during a conversion. It changes only on the edge where `busyN` returns high.
- R7: After the transfer, `trialCode` is zero, and it stays zero while the block is idle.
- R8: A start request from either source while `busyN` is low is ignored. The running conversion still ends after DATA_W cycles, and no new conversion follows.
- R9: `clkEnable` is high exactly while a conversion runs, and low at all other times.
- R10: A synchronous `rst` clears `trialCode` and `result`, sets `busyN` high, sets `holdMode` to track and drops `clkEnable`. This holds even when `rst` arrives during a conversion.
- R11: While idle, clock edges and changes on `cmpHigh` leave `result`, `trialCode` and `busyN` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| startStrobe | input | 1 | Dedicated start request |
| chipSel | input | 1 | Chip select, forms a start together with readEn |
| readEn | input | 1 | Read enable, forms a start together with chipSel |
| cmpHigh | input | 1 | Comparator: 1 when input is at or above the trial level |
| trialCode | output | DATA_W | Approximation register, drives the internal DAC |
| result | output | DATA_W | Output latch with the last completed code |
| busyN | output | 1 | Active-low busy, low during a conversion |
| holdMode | output | 1 | 1 = hold, 0 = track |
| clkEnable | output | 1 | Conversion clock enable, low when idle |

## Verification
The bench builds the block with the default DATA_W of 8, so an input code maps one-to-one onto the eight trial cycles. The comparator is modelled as the test input code compared against `trialCode`, which gives a complete binary search for every chosen code. The chosen codes include the all-zero and all-one extremes and the codes on either side of mid-scale. With a width of 8, the busy window can be counted cycle by cycle. Within that window the bench can inject restart attempts and a reset at chosen trial positions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef struct packed {
    logic load;   // start accepted: seed MSB trial
    logic trial;  // resolve current bit
    logic xfer;   // last trial: move to output latch, clear register
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       startStrobe,
  input  logic                       chipSel,
  input  logic                       readEn,
  output seqStrobe_t                 strb,
  output logic [$clog2(DATA_W)-1:0]  bitPos,
  output logic                       busyN,
  output logic                       holdMode,
  output logic                       clkEnable
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] trialCnt;
  logic             startReq;

  assign startReq = startStrobe | (chipSel & readEn);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyN     <= 1'b1;
      holdMode  <= 1'b0;
      clkEnable <= 1'b0;
      trialCnt  <= '0;
    end else if (busyN) begin
      if (startReq) begin
        busyN     <= 1'b0;
        holdMode  <= 1'b1;
        clkEnable <= 1'b1;
        trialCnt  <= '0;
      end
    end else if (trialCnt == LAST) begin
      busyN     <= 1'b1;
      holdMode  <= 1'b0;
      clkEnable <= 1'b0;
      trialCnt  <= '0;
    end else begin
      trialCnt <= trialCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load  = busyN & startReq;
    strb.trial = ~busyN;
    strb.xfer  = ~busyN & (trialCnt == LAST);
    bitPos     = LAST - trialCnt;
  end

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!busyN && trialCnt == LAST) |=> busyN);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!busyN && trialCnt != LAST) |=> (!busyN && trialCnt == $past(trialCnt) + 1'b1));

  // R4
  hold_match_chk: assert property (@(posedge clk) disable iff (rst)
    holdMode == !busyN);

  // R9
  clk_en_chk: assert property (@(posedge clk) disable iff (rst)
    clkEnable == !busyN);
endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  seqStrobe_t                 strb,
  input  logic [$clog2(DATA_W)-1:0]  bitPos,
  input  logic                       cmpHigh,
  output logic [DATA_W-1:0]          trialCode,
  output logic [DATA_W-1:0]          result
);
  localparam logic [DATA_W-1:0] MSB_TRIAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] decided;

  // keep or drop the bit under test, arm the next lower trial bit
  always_comb begin
    decided = trialCode;
    for (int i = 0; i < DATA_W; i++) begin
      if (i == int'(bitPos))
        decided[i] = cmpHigh;
      else if (i + 1 == int'(bitPos))
        decided[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trialCode <= '0;
      result    <= '0;
    end else if (strb.load) begin
      trialCode <= MSB_TRIAL;
    end else if (strb.xfer) begin
      result    <= decided;
      trialCode <= '0;
    end else if (strb.trial) begin
      trialCode <= decided;
    end
  end

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.xfer |=> $stable(result));

  // R7
  sar_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.xfer |=> trialCode == '0);

  // R5
  msb_seed_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> trialCode == MSB_TRIAL);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startStrobe,
  input  logic              chipSel,
  input  logic              readEn,
  input  logic              cmpHigh,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] result,
  output logic              busyN,
  output logic              holdMode,
  output logic              clkEnable
);
  localparam int IDX_W = $clog2(DATA_W);

  seqStrobe_t       strb;
  logic [IDX_W-1:0] bitPos;

  sar_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .startStrobe(startStrobe), .chipSel(chipSel),
    .readEn(readEn), .strb(strb), .bitPos(bitPos), .busyN(busyN),
    .holdMode(holdMode), .clkEnable(clkEnable)
  );

  sar_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .bitPos(bitPos), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .result(result)
  );
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst, startStrobe, chipSel, readEn, cmpHigh;
  logic [DATA_W-1:0] vin, trialCode, result;
  logic busyN, holdMode, clkEnable;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  assign cmpHigh = (vin >= trialCode);

  sar_conv_seq #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .startStrobe(startStrobe), .chipSel(chipSel),
    .readEn(readEn), .cmpHigh(cmpHigh), .trialCode(trialCode), .result(result),
    .busyN(busyN), .holdMode(holdMode), .clkEnable(clkEnable)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleState(input string tag, input int expRes);
    check(busyN == 1'b1, {tag, " busyN"}, busyN, 1);
    check(holdMode == 1'b0, {tag, " holdMode"}, holdMode, 0);
    check(clkEnable == 1'b0, {tag, " clkEnable"}, clkEnable, 0);
    check(trialCode == '0, {tag, " trialCode"}, trialCode, 0);
    check(result == expRes[DATA_W-1:0], {tag, " result"}, result, expRes);
  endtask

  // one conversion; src 0 = strobe, 1 = chipSel&readEn; intrude = cycle to poke a restart (-1 none)
  task automatic convert(input logic [DATA_W-1:0] code, input int src, input int intrude, input string tag);
    logic [DATA_W-1:0] prev;
    int lowCnt;
    prev = result;
    vin = code;
    if (src == 0) startStrobe = 1'b1; else begin chipSel = 1'b1; readEn = 1'b1; end
    @(negedge clk);
    startStrobe = 1'b0; chipSel = 1'b0; readEn = 1'b0;
    lowCnt = 0;
    for (int k = 0; k < DATA_W; k++) begin
      if (busyN == 1'b0) lowCnt++;
      check(holdMode == !busyN, {tag, " R4 hold in window"}, holdMode, 1);
      check(clkEnable == !busyN, {tag, " R9 clock enable in window"}, clkEnable, 1);
      check(result == prev, {tag, " R6 result held"}, result, prev);
      if (k == intrude) begin startStrobe = 1'b1; chipSel = 1'b1; readEn = 1'b1; end
      @(negedge clk);
      startStrobe = 1'b0; chipSel = 1'b0; readEn = 1'b0;
    end
    check(lowCnt == DATA_W, {tag, " R3 busy length"}, lowCnt, DATA_W);
    idleState({tag, " R5 R7 end"}, int'(code));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; startStrobe = 1'b0; chipSel = 1'b0; readEn = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idleState("R10 reset", 0);

    // R1 strobe start and R5 binary search over several codes
    convert(8'hA5, 0, -1, "R1 a5");
    convert(8'h00, 0, -1, "R5 zero");
    convert(8'hFF, 0, -1, "R5 full");
    convert(8'h80, 1, -1, "R2 mid");
    convert(8'h7F, 1, -1, "R2 below-mid");
    convert(8'h5A, 0, -1, "R5 5a");

    // R2 partial selects do not start
    chipSel = 1'b1; @(negedge clk); chipSel = 1'b0;
    check(busyN == 1'b1, "R2 chipSel alone", busyN, 1);
    readEn = 1'b1; @(negedge clk); readEn = 1'b0;
    check(busyN == 1'b1, "R2 readEn alone", busyN, 1);

    // R8 restart attempts during conversion are ignored
    convert(8'h33, 0, 3, "R8 mid restart");
    convert(8'hC4, 1, DATA_W - 2, "R8 late restart");
    @(negedge clk);
    check(busyN == 1'b1, "R8 no follow-on conversion", busyN, 1);

    // R11 idle clocks with comparator activity
    for (int k = 0; k < 10; k++) begin
      vin = DATA_W'(k * 37);
      @(negedge clk);
    end
    idleState("R11 idle", 'hC4);

    // R10 reset during a conversion
    vin = 8'h9C; startStrobe = 1'b1;
    @(negedge clk); startStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check(busyN == 1'b0, "R10 pre-reset busy", busyN, 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    idleState("R10 mid reset", 0);
    convert(8'h9C, 0, -1, "R10 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule